// File: doc/BRIEF.md
# BCD Calendar Counter with Leap-Year Offset

This block keeps the time-of-day and calendar counters of a small real-time clock. Seconds, minutes, hours, day of month, month, a two-digit year and a day of the week are each kept as 4-bit BCD digits. A single-cycle `tick` strobe, one per second from an external crystal divider, advances the seconds. Each counter that wraps carries into the next one up. Hours run in 24-hour form. Day of month wraps according to the month length, and February's length depends on a leap test.

The leap test uses a 2-bit offset that is stored in the upper bits of the month-tens digit. A year is a leap year when the two-digit year value modulo 4 equals that offset. This lets the year digits hold any era numbering. A seconds-clear command zeroes the seconds and rounds into the minutes when the seconds were at 30 or more. A host port writes any single digit and reads any digit by index. Reading the month-tens digit also shows whether the current year is a leap year.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, time reads 00:00:00, date reads day 01, month 01, year 00, day of week 0, and the leap offset is 0. Digit index 9 reads 4'b0010 because year 00 matches offset 0.
- R2: Digit indices are: 0/1 seconds units/tens, 2/3 minutes, 4/5 hours, 6/7 day, 8/9 month, 10/11 year, 12 day of week. Each `tick` pulse with no clear command and no write raises the seconds value by one.
- R3: Seconds and minutes wrap 59 to 00 and carry up. Hours wrap 23 to 00 and carry into the day of month and the day of week.
- R4: The day of week counts 0 to 6 and wraps to 0 on each day rollover.
- R5: The day of month wraps to 01 after 30 in months 4, 6, 9 and 11, and after 31 in the other months except February. Month 12 wraps to 01 and carries into the year.
- R6: The year counts 00 to 99 and wraps from 99 to 00.
- R7: Bits 3:2 of digit 9 hold the leap offset, and bit 0 holds the month tens value. The year is a leap year when (year mod 4) equals the offset. In a leap year, February 28 is followed by 29 and then March 1. In other years, February 28 is followed by March 1.
- R8: Reading digit 9 returns the leap-year flag in bit 1. The `leap_year` output carries the same flag.
- R9: `sec_clr` sets the seconds to 00. If the seconds were 30 or more, it carries into the minutes through the normal carry chain. When `sec_clr` and `tick` arrive in the same cycle, the clear wins and the tick is dropped.
- R10: A write changes only the addressed digit. It overrides that digit's own update in the same cycle, but carries are still computed from the old values. Writes to indices 13 to 15 change nothing, and reads of those indices return 0.
- R11: In a cycle with no tick, no clear and no write, every counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe, once per second |
| sec_clr | input | 1 | Seconds-clear command with rounding into minutes |
| wr_en | input | 1 | Digit write strobe |
| wr_idx | input | IW | Index of the digit to write |
| wr_data | input | 4 | Digit value to write |
| rd_idx | input | IW | Index of the digit to read |
| rd_data | output | 4 | Selected digit, combinational |
| leap_year | output | 1 | Current year matches the leap offset |

## Verification
The hardest case to reach from the ports is the February rollover, because it only happens once per simulated year. Each offset setting must also be tried against both a matching and a non-matching year. The stimulus writes the calendar straight to February 28, 23:59:59 with the chosen year and offset, then applies one tick. It does this for all four offset values. Writes are also placed on the same edge as a tick at 59 seconds, which shows that the carry still uses the pre-write value.

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          sec_clr,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [3:0]    wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [3:0]    rd_data,
  output logic          leap_year
);
  localparam int NDIG = 13;
  localparam int MT   = 9;
  localparam int DOW  = 12;

  function automatic logic [6:0] bin(input logic [3:0] t, input logic [3:0] u);
    return 7'(t) * 7'd10 + 7'(u);
  endfunction

  function automatic logic [7:0] bcd(input logic [6:0] v);
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  logic [3:0] dg [NDIG];
  logic [3:0] nx [NDIG];

  logic [6:0] sec_v, min_v, hr_v, day_v, mon_v, yr_v, dmax;
  logic [6:0] sec_n, min_n, hr_n, day_n, mon_n, yr_n;
  logic [3:0] dow_n;
  logic [7:0] mon_b;
  logic [1:0] yr_mod;
  logic       c_sec, c_min, c_hr, c_day, c_mon;

  assign sec_v = bin(dg[1], dg[0]);
  assign min_v = bin(dg[3], dg[2]);
  assign hr_v  = bin(dg[5], dg[4]);
  assign day_v = bin(dg[7], dg[6]);
  assign mon_v = bin({3'b000, dg[MT][0]}, dg[8]);
  assign yr_v  = bin(dg[11], dg[10]);

  assign yr_mod    = {dg[11][0], 1'b0} + dg[10][1:0];
  assign leap_year = (yr_mod == dg[MT][3:2]);

  always_comb begin
    case (mon_v)
      7'd2:                    dmax = leap_year ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11: dmax = 7'd30;
      default:                 dmax = 7'd31;
    endcase
  end

  assign c_sec = sec_clr ? (sec_v >= 7'd30) : (tick && sec_v >= 7'd59);
  assign c_min = c_sec && min_v >= 7'd59;
  assign c_hr  = c_min && hr_v >= 7'd23;
  assign c_day = c_hr && day_v >= dmax;
  assign c_mon = c_day && mon_v >= 7'd12;

  assign sec_n = sec_clr ? 7'd0 : !tick ? sec_v : (sec_v >= 7'd59) ? 7'd0 : sec_v + 7'd1;
  assign min_n = !c_sec ? min_v : (min_v >= 7'd59) ? 7'd0 : min_v + 7'd1;
  assign hr_n  = !c_min ? hr_v  : (hr_v  >= 7'd23) ? 7'd0 : hr_v + 7'd1;
  assign day_n = !c_hr  ? day_v : (day_v >= dmax)  ? 7'd1 : day_v + 7'd1;
  assign mon_n = !c_day ? mon_v : (mon_v >= 7'd12) ? 7'd1 : mon_v + 7'd1;
  assign yr_n  = !c_mon ? yr_v  : (yr_v  >= 7'd99) ? 7'd0 : yr_v + 7'd1;
  assign dow_n = !c_hr  ? dg[DOW] : (dg[DOW] >= 4'd6) ? 4'd0 : dg[DOW] + 4'd1;
  assign mon_b = bcd(mon_n);

  always_comb begin
    {nx[1], nx[0]}   = bcd(sec_n);
    {nx[3], nx[2]}   = bcd(min_n);
    {nx[5], nx[4]}   = bcd(hr_n);
    {nx[7], nx[6]}   = bcd(day_n);
    nx[8]            = mon_b[3:0];
    nx[MT]           = {dg[MT][3:2], 1'b0, mon_b[4]};
    {nx[11], nx[10]} = bcd(yr_n);
    nx[DOW]          = dow_n;
    for (int k = 0; k < NDIG; k++)
      if (wr_en && wr_idx == IW'(k))
        nx[k] = (k == MT) ? {wr_data[3:2], 1'b0, wr_data[0]} : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NDIG; k++)
        dg[k] <= (k == 6 || k == 8) ? 4'd1 : 4'd0;
    end else begin
      for (int k = 0; k < NDIG; k++)
        dg[k] <= nx[k];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NDIG; k++)
      if (rd_idx == IW'(k))
        rd_data = (k == MT) ? {dg[MT][3:2], leap_year, dg[MT][0]} : dg[k];
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          sec_clr,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic [3:0]    wr_data,
  input logic          leap_year,
  input logic [6:0]    sec_v,
  input logic [6:0]    min_v,
  input logic [6:0]    hr_v,
  input logic [6:0]    day_v,
  input logic [6:0]    mon_v,
  input logic [6:0]    yr_v,
  input logic [3:0]    dow,
  input logic [3:0]    su
);
  logic day_roll;
  assign day_roll = tick && !sec_clr && !wr_en && sec_v == 7'd59 && min_v == 7'd59 && hr_v == 7'd23;

  assert_sec_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !sec_clr && !wr_en && sec_v < 7'd59 |=> sec_v == 7'($past(sec_v) + 7'd1));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_clr && !wr_en |=> sec_v == 7'd0);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !sec_clr && !wr_en |=> $stable(sec_v) && $stable(min_v) && $stable(hr_v)
      && $stable(day_v) && $stable(mon_v) && $stable(yr_v) && $stable(dow) && $stable(leap_year));

  assert_dow_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    day_roll && dow == 4'd6 |=> dow == 4'd0);

  assert_feb_common_R7: assert property (@(posedge clk) disable iff (!rst_n)
    day_roll && mon_v == 7'd2 && day_v == 7'd28 && !leap_year |=> mon_v == 7'd3 && day_v == 7'd1);

  assert_feb_leap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    day_roll && mon_v == 7'd2 && day_v == 7'd28 && leap_year |=> mon_v == 7'd2 && day_v == 7'd29);

  assert_year_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    day_roll && mon_v == 7'd12 && day_v == 7'd31 && yr_v == 7'd99 |=> yr_v == 7'd0 && mon_v == 7'd1);

  assert_digit_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_idx == IW'(0) |=> su == $past(wr_data));
endmodule

bind rtc_calendar rtc_calendar_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sec_clr(sec_clr),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .leap_year(leap_year),
  .sec_v(sec_v), .min_v(min_v), .hr_v(hr_v), .day_v(day_v),
  .mon_v(mon_v), .yr_v(yr_v), .dow(dg[12]), .su(dg[0])
);

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
  logic       clk = 0, rst_n = 0, tick = 0, sec_clr = 0, wr_en = 0;
  logic [3:0] wr_idx = 0, wr_data = 0, rd_idx = 0;
  logic [3:0] rd_data;
  logic       leap_year;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  rtc_calendar u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sec_clr(sec_clr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .leap_year(leap_year)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic rd(input int idx, output int v);
    @(negedge clk);
    rd_idx = 4'(idx);
    #1 v = int'(rd_data);
  endtask

  task automatic wr(input int idx, input int d);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(idx); wr_data = 4'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse(input bit t, input bit c);
    @(negedge clk);
    tick = t; sec_clr = c;
    @(negedge clk);
    tick = 0; sec_clr = 0;
  endtask

  task automatic pair(input int ti, input int ui, output int v);
    int t, u;
    rd(ti, t);
    rd(ui, u);
    if (ti == 9) t = t & 1;
    v = t * 10 + u;
  endtask

  task automatic set_time(input int yr, input int mo, input int dy, input int hr,
                          input int mi, input int se, input int dw, input int sel);
    wr(0, se % 10);  wr(1, se / 10);
    wr(2, mi % 10);  wr(3, mi / 10);
    wr(4, hr % 10);  wr(5, hr / 10);
    wr(6, dy % 10);  wr(7, dy / 10);
    wr(8, mo % 10);  wr(9, sel * 4 + mo / 10);
    wr(10, yr % 10); wr(11, yr / 10);
    wr(12, dw);
  endtask

  task automatic check_all(input string req, input int date, input int tod);
    int yr, mo, dy, hr, mi, se;
    pair(11, 10, yr); pair(9, 8, mo); pair(7, 6, dy);
    pair(5, 4, hr);   pair(3, 2, mi); pair(1, 0, se);
    check({req, " date"}, yr * 10000 + mo * 100 + dy, date);
    check({req, " time"}, hr * 10000 + mi * 100 + se, tod);
  endtask

  task automatic t_reset();
    int v;
    check_all("R1", 101, 0);
    rd(12, v); check("R1 dow", v, 0);
    rd(9, v);  check("R1/R8 month tens", v, 2);
    check("R8 leap port", int'(leap_year), 1);
  endtask

  task automatic t_tick();
    pulse(1, 0); pulse(1, 0); pulse(1, 0);
    check_all("R2 three ticks", 101, 3);
    repeat (5) @(negedge clk);
    check_all("R11 idle hold", 101, 3);
  endtask

  task automatic t_cascade();
    int v;
    set_time(23, 5, 15, 23, 59, 59, 6, 0);
    pulse(1, 0);
    check_all("R3 hour wrap", 230516, 0);
    rd(12, v); check("R4 dow wrap", v, 0);
    set_time(23, 5, 16, 10, 59, 59, 2, 0);
    pulse(1, 0);
    check_all("R3 minute carry", 230516, 110000);
  endtask

  task automatic t_months();
    set_time(23, 4, 30, 23, 59, 59, 1, 0);
    pulse(1, 0);
    check_all("R5 april end", 230501, 0);
    set_time(23, 1, 30, 23, 59, 59, 1, 0);
    pulse(1, 0);
    check_all("R5 january 31", 230131, 0);
    set_time(99, 12, 31, 23, 59, 59, 1, 0);
    pulse(1, 0);
    check_all("R6 year wrap", 101, 0);
  endtask

  task automatic t_leap();
    int v, yr;
    for (int sel = 0; sel < 4; sel++) begin
      for (int m = 0; m < 2; m++) begin
        yr = 24 + ((m == 0) ? sel : (sel + 1) % 4);
        set_time(yr, 2, 28, 23, 59, 59, 3, sel);
        rd(9, v);
        check("R8 leap bit", (v >> 1) & 1, (m == 0) ? 1 : 0);
        check("R7 offset field", v >> 2, sel);
        pulse(1, 0);
        check_all("R7 feb 28", (m == 0) ? yr * 10000 + 229 : yr * 10000 + 301, 0);
        if (m == 0) begin
          set_time(yr, 2, 29, 23, 59, 59, 3, sel);
          pulse(1, 0);
          check_all("R7 feb 29", yr * 10000 + 301, 0);
        end
      end
    end
  endtask

  task automatic t_clear();
    set_time(30, 6, 10, 8, 10, 45, 0, 0);
    pulse(0, 1);
    check_all("R9 round up", 300610, 81100);
    set_time(30, 6, 10, 8, 10, 29, 0, 0);
    pulse(0, 1);
    check_all("R9 round down", 300610, 81000);
    set_time(30, 6, 10, 8, 10, 12, 0, 0);
    pulse(1, 1);
    check_all("R9 clear beats tick", 300610, 81000);
    set_time(99, 12, 31, 23, 59, 45, 0, 0);
    pulse(0, 1);
    check_all("R9 full carry", 101, 0);
  endtask

  task automatic t_write();
    int v;
    set_time(40, 7, 20, 10, 20, 37, 0, 0);
    @(negedge clk);
    tick = 1; wr_en = 1; wr_idx = 4'd0; wr_data = 4'd5;
    @(negedge clk);
    tick = 0; wr_en = 0;
    check_all("R10 write beats tick", 400720, 102035);
    set_time(40, 7, 20, 10, 20, 59, 0, 0);
    @(negedge clk);
    tick = 1; wr_en = 1; wr_idx = 4'd1; wr_data = 4'd2;
    @(negedge clk);
    tick = 0; wr_en = 0;
    check_all("R10 carry from old", 400720, 102120);
    wr(14, 7);
    check_all("R10 bad index ignored", 400720, 102120);
    rd(14, v); check("R10 bad index reads 0", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_tick();
    t_cascade();
    t_months();
    t_leap();
    t_clear();
    t_write();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog all got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule